// File: doc/BRIEF.md
# LCD Controller Reset and Chip-Select Sequencer

This block owns the reset behaviour and the chip-selection logic of a small multiplexed LCD controller. A raw active-high reset input is synchronised into the core clock. While it is held, the block stops all command, data and display-readout processing. It also forces the controller's setup registers to their defaults and keeps the display blanked. A standby flag is deliberately left untouched by reset, so a controller that was asleep stays asleep.

When the synchronised reset falls, two strap inputs are captured. One enables chip-address selection for multi-chip systems. The other chooses a serial or a parallel host interface. The chip is selected when chip-select is low and the two chip-address pins equal an internal compare value, which reset forces to zero. With address selection strapped off, the chip is selected whenever chip-select is low. The active-low busy line is modelled as a level and a separate output enable, so the floating state can be seen directly.

Commands arrive as an opcode with an argument and take effect only while the chip is selected and out of reset. A power-on input clears every flop, standby included, to a known state.

Top module: `lcd_rst_sel`

## Requirements
- R1: One clock edge after `proc_en_o` reads low, `wr_mode_o` is 2'b00, `data_ptr_o` is 0, `mode_o` is 3'b000 and `frame_div_o` is 3'b000. `proc_en_o` is low exactly while the synchronised reset is high.
- R2: `byte_cnt_o` counts `byte_done_i` pulses modulo 8 while out of reset, and reset clears it to 0.
- R3: While reset is active, the internal chip-address compare value is 2'b00. With address selection strapped on, only `caddr_i` = 2'b00 matches during reset.
- R4: With address selection on and `caddr_i` equal to the compare value, `busy_oe_o` is 1 when `cs_n_i` is 0 and 0 when `cs_n_i` is 1.
- R5: With address selection on and `caddr_i` different from the compare value, `busy_oe_o` is 0 for either level of `cs_n_i`.
- R6: With address selection strapped off, `busy_oe_o` equals the inverse of `cs_n_i`, whatever `caddr_i` and the compare value are.
- R7: `busy_o` is 0 while reset is active and 1 once processing is enabled.
- R8: `addr_en_o` and `par_mode_o` take the strap values present in the cycle in which the falling reset edge is seen. They do not change at any other time.
- R9: Reset neither sets nor clears `standby_o`. Its value before reset remains through and after reset.
- R10: Reset sets `disp_off_o` to 1. After reset, it stays 1 until a display-on command (opcode 4) is accepted. Opcode 5 sets it again.
- R11: A command is accepted only when `cmd_valid_i` is 1, the chip is selected and reset is inactive. At any other time it has no effect. Opcodes, with the argument in `cmd_arg_i`: 0 write mode (arg[1:0]), 1 data pointer (arg[6:0]), 2 mode (arg[2:0]), 3 frame divider (arg[2:0]), 4 display on, 5 display off, 6 standby on, 7 standby off, 8 compare value (arg[1:0]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| por_n_i | input | 1 | Asynchronous power-on clear, active low |
| rst_i | input | 1 | Raw controller reset, active high, asynchronous to clk_i |
| cs_n_i | input | 1 | Chip select, active low |
| caddr_i | input | 2 | Chip-address pins |
| strap_addr_en_i | input | 1 | Strap: enable chip-address selection |
| strap_par_i | input | 1 | Strap: 1 parallel, 0 serial interface |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 4 | Command opcode |
| cmd_arg_i | input | 7 | Command argument |
| byte_done_i | input | 1 | Byte-transfer-end pulse |
| wr_mode_o | output | 2 | Write mode register |
| data_ptr_o | output | 7 | Data pointer register |
| mode_o | output | 3 | Multiplex/bank mode register |
| frame_div_o | output | 3 | Frame-frequency select register |
| byte_cnt_o | output | 3 | Byte-transfer-end counter |
| standby_o | output | 1 | Standby flag |
| proc_en_o | output | 1 | Processing enable |
| disp_off_o | output | 1 | Display forced off |
| addr_en_o | output | 1 | Latched address-selection strap |
| par_mode_o | output | 1 | Latched interface strap |
| busy_o | output | 1 | Busy level, active low |
| busy_oe_o | output | 1 | Busy output enable; 0 means floating |

## Verification
The assertions assume that `por_n_i` is pulsed low once at start and then stays high. They also assume that `rst_i` changes only on a clock's inactive edge and is held for several cycles, so that the synchroniser has settled. The bench drives every input on the falling clock edge and holds each reset phase for four cycles. The straps are set before reset is released and flipped afterwards, so that any capture outside the falling edge would show. Chip select and chip address are swept over every combination against each compare value, with address selection both on and off.

// File: rtl/lcd_rst_sel.sv
module lcd_rst_sel (
  input  logic       clk_i,
  input  logic       por_n_i,
  input  logic       rst_i,
  input  logic       cs_n_i,
  input  logic [1:0] caddr_i,
  input  logic       strap_addr_en_i,
  input  logic       strap_par_i,
  input  logic       cmd_valid_i,
  input  logic [3:0] cmd_op_i,
  input  logic [6:0] cmd_arg_i,
  input  logic       byte_done_i,
  output logic [1:0] wr_mode_o,
  output logic [6:0] data_ptr_o,
  output logic [2:0] mode_o,
  output logic [2:0] frame_div_o,
  output logic [2:0] byte_cnt_o,
  output logic       standby_o,
  output logic       proc_en_o,
  output logic       disp_off_o,
  output logic       addr_en_o,
  output logic       par_mode_o,
  output logic       busy_o,
  output logic       busy_oe_o
);

  logic       rst_s1, rst_s2, rst_q;
  logic [1:0] cmp_q;
  logic       fall, match, sel, accept;

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      rst_s1 <= 1'b1;
      rst_s2 <= 1'b1;
      rst_q  <= 1'b1;
    end else begin
      rst_s1 <= rst_i;
      rst_s2 <= rst_s1;
      rst_q  <= rst_s2;
    end
  end

  assign fall      = rst_q & ~rst_s2;
  assign match     = ~addr_en_o | (caddr_i == cmp_q);
  assign sel       = ~cs_n_i & match;
  assign accept    = cmd_valid_i & sel & ~rst_s2;
  assign proc_en_o = ~rst_s2;
  assign busy_o    = ~rst_s2;
  assign busy_oe_o = sel;

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      wr_mode_o   <= 2'b00;
      data_ptr_o  <= 7'd0;
      mode_o      <= 3'b000;
      frame_div_o <= 3'b000;
      byte_cnt_o  <= 3'd0;
      cmp_q       <= 2'b00;
      disp_off_o  <= 1'b1;
      standby_o   <= 1'b0;
      addr_en_o   <= 1'b0;
      par_mode_o  <= 1'b0;
    end else begin
      if (fall) begin
        addr_en_o  <= strap_addr_en_i;
        par_mode_o <= strap_par_i;
      end
      if (rst_s2) begin
        wr_mode_o   <= 2'b00;
        data_ptr_o  <= 7'd0;
        mode_o      <= 3'b000;
        frame_div_o <= 3'b000;
        byte_cnt_o  <= 3'd0;
        cmp_q       <= 2'b00;
        disp_off_o  <= 1'b1;
      end else begin
        if (byte_done_i) byte_cnt_o <= byte_cnt_o + 3'd1;
        if (accept) begin
          case (cmd_op_i)
            4'd0: wr_mode_o   <= cmd_arg_i[1:0];
            4'd1: data_ptr_o  <= cmd_arg_i;
            4'd2: mode_o      <= cmd_arg_i[2:0];
            4'd3: frame_div_o <= cmd_arg_i[2:0];
            4'd4: disp_off_o  <= 1'b0;
            4'd5: disp_off_o  <= 1'b1;
            4'd6: standby_o   <= 1'b1;
            4'd7: standby_o   <= 1'b0;
            4'd8: cmp_q       <= cmd_arg_i[1:0];
            default: ;
          endcase
        end
      end
    end
  end

endmodule

module lcd_rst_sel_chk (
  input logic       clk_i,
  input logic       por_n_i,
  input logic       cs_n_i,
  input logic [1:0] caddr_i,
  input logic [1:0] cmp_q,
  input logic       proc_en_o,
  input logic [1:0] wr_mode_o,
  input logic [6:0] data_ptr_o,
  input logic [2:0] mode_o,
  input logic [2:0] frame_div_o,
  input logic [2:0] byte_cnt_o,
  input logic       standby_o,
  input logic       disp_off_o,
  input logic       addr_en_o,
  input logic       par_mode_o,
  input logic       busy_o,
  input logic       busy_oe_o
);

  // R1
  reset_defaults_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !proc_en_o |=> (wr_mode_o == 2'b00 && data_ptr_o == 7'd0 && mode_o == 3'b000 && frame_div_o == 3'b000));

  // R2
  byte_cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !proc_en_o |=> byte_cnt_o == 3'd0);

  // R3
  cmp_zero_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !proc_en_o |=> cmp_q == 2'b00);

  // R5
  no_match_float_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (addr_en_o && caddr_i != cmp_q) |-> !busy_oe_o);

  // R4
  cs_high_float_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    cs_n_i |-> !busy_oe_o);

  // R7
  busy_level_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    busy_o == proc_en_o);

  // R8
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (proc_en_o && $past(proc_en_o) && $past(proc_en_o, 2)) |-> ($stable(addr_en_o) && $stable(par_mode_o)));

  // R9
  standby_keep_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !proc_en_o |=> $stable(standby_o));

  // R10
  disp_off_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !proc_en_o |=> disp_off_o);

endmodule

bind lcd_rst_sel lcd_rst_sel_chk u_chk (.*);

// File: tb/lcd_rst_sel_bench.sv
module lcd_rst_sel_bench;
  logic clk = 1'b0;
  logic por_n, rst, cs_n, sa, sp, cv, bd;
  logic [1:0] ca;
  logic [3:0] op;
  logic [6:0] arg;
  logic [1:0] wm;
  logic [6:0] ptr;
  logic [2:0] md, fd, bc;
  logic stb, pen, doff, aen, pm, busy, boe;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  lcd_rst_sel u_lcd_rst_sel (
    .clk_i(clk), .por_n_i(por_n), .rst_i(rst), .cs_n_i(cs_n), .caddr_i(ca),
    .strap_addr_en_i(sa), .strap_par_i(sp), .cmd_valid_i(cv), .cmd_op_i(op),
    .cmd_arg_i(arg), .byte_done_i(bd), .wr_mode_o(wm), .data_ptr_o(ptr),
    .mode_o(md), .frame_div_o(fd), .byte_cnt_o(bc), .standby_o(stb),
    .proc_en_o(pen), .disp_off_o(doff), .addr_en_o(aen), .par_mode_o(pm),
    .busy_o(busy), .busy_oe_o(boe));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] o, input logic [6:0] a);
    @(negedge clk); cv = 1'b1; op = o; arg = a;
    @(negedge clk); cv = 1'b0;
  endtask

  task automatic pulse_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bd = 1'b1;
      @(negedge clk); bd = 1'b0;
    end
  endtask

  task automatic enter_reset();
    @(negedge clk); rst = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic leave_reset(input logic a, input logic p);
    @(negedge clk); sa = a; sp = p; rst = 1'b0;
    repeat (4) @(negedge clk);
    sa = ~a; sp = ~p;
  endtask

  task automatic sweep(input string req, input logic ae, input logic [1:0] cmpv);
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 2; s++) begin
        ca = c[1:0]; cs_n = s[0];
        #1;
        check(req, boe, !s[0] && (!ae || c[1:0] == cmpv));
      end
    end
    cs_n = 1'b0; ca = 2'b00;
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [1:0] prev;
    por_n = 1'b0; rst = 1'b1; cs_n = 1'b0; ca = 2'b00; sa = 1'b0; sp = 1'b0;
    cv = 1'b0; op = 4'd0; arg = 7'd0; bd = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 proc_en in reset", pen, 0);
    check("R1 defaults", {wm, ptr, md, fd}, 15'd0);
    check("R7 busy low in reset", busy, 0);
    leave_reset(1'b0, 1'b0);
    check("R7 busy high", busy, 1);
    check("R1 proc_en", pen, 1);
    check("R10 display off after release", doff, 1);
    cmd(4'd0, 7'd2); cmd(4'd1, 7'h55); cmd(4'd2, 7'd5); cmd(4'd3, 7'd6);
    cmd(4'd6, 7'd0); cmd(4'd4, 7'd0);
    pulse_bytes(3);
    check("R11 write registers", {wm, ptr, md, fd}, {2'd2, 7'h55, 3'd5, 3'd6});
    check("R2 count", bc, 3);
    check("R10 display on", doff, 0);
    check("R9 standby set", stb, 1);
    enter_reset();
    check("R1 defaults after reset", {wm, ptr, md, fd}, 15'd0);
    check("R2 cleared", bc, 0);
    check("R10 display off in reset", doff, 1);
    check("R9 standby kept in reset", stb, 1);
    check("R7 busy low", busy, 0);
    cmd(4'd1, 7'h22);
    pulse_bytes(2);
    leave_reset(1'b1, 1'b1);
    check("R8 addr strap", aen, 1);
    check("R8 par strap", pm, 1);
    check("R11 cmd in reset ignored", ptr, 0);
    check("R2 pulses in reset ignored", bc, 0);
    check("R9 standby kept after", stb, 1);
    check("R10 still off", doff, 1);
    repeat (3) @(negedge clk);
    check("R8 straps stable", {aen, pm}, 2'b11);
    cs_n = 1'b1; cmd(4'd4, 7'd0); cs_n = 1'b0;
    check("R11 deselected ignored", doff, 1);
    ca = 2'b01; cmd(4'd4, 7'd0); ca = 2'b00;
    check("R11 mismatch ignored", doff, 1);
    cmd(4'd4, 7'd0);
    check("R10 display on cmd", doff, 0);
    cmd(4'd5, 7'd0);
    check("R10 display off cmd", doff, 1);
    cmd(4'd7, 7'd0);
    check("R11 standby off", stb, 0);
    prev = 2'b00;
    for (int v = 0; v < 4; v++) begin
      if (v != 0) begin
        ca = prev; cs_n = 1'b0; cmd(4'd8, 7'(v)); prev = v[1:0];
      end
      sweep("R4 R5 match sweep", 1'b1, v[1:0]);
    end
    enter_reset();
    sweep("R3 compare zero in reset", 1'b1, 2'b00);
    leave_reset(1'b0, 1'b0);
    check("R8 straps second", {aen, pm}, 2'b00);
    cmd(4'd8, 7'd2);
    sweep("R6 single chip", 1'b0, 2'b10);
    pulse_bytes(9);
    check("R2 wrap", bc, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule